// File: doc/BRIEF.md
# Bit-Serial Operand Adder

This block adds two unsigned words of `N` bits using one full-adder cell and a carry flip-flop instead of an `N`-bit parallel adder. A request loads both operands into shift registers. These registers then feed one bit pair per clock, lowest bit first, into a small carry-state machine. Every sum bit produced is shifted into a result register from the top, so after the last step the word is aligned. Because only the carry persists between steps, the same structure works for any operand length.

The parameter `MOORE` selects the timing of the core. With `MOORE = 0`, a two-state core (carry clear / carry set) forms each sum bit combinationally from the current operand bits and the carry. The operation takes `N` shift steps. With `MOORE = 1`, a four-state core keeps the sum bit in a flip-flop next to the carry. Each sum bit therefore leaves the core one clock late. The block runs one extra step to flush it out, and the first captured bit, which comes from the cleared state, falls off the bottom of the result register.

Operands enter through a valid/ready handshake. `in_ready` is high only while the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While an addition is in progress, `in_ready` stays low and the block ignores `in_valid`, so the upstream side must hold its request until it is accepted. The result side has no back-pressure. `done` pulses for one cycle, and `sum` and `carry_out` then hold their values until the next request is accepted.

Top module: `serial_adder`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, `sum` is 0 and `carry_out` is 0.
- R2: With `MOORE = 0`, once `done` is 1, `sum` equals (`in_a` + `in_b`) mod 2^N and `carry_out` equals bit N of the full N+1-bit sum, using the operands captured at acceptance.
- R3: With `MOORE = 0`, `done` is 1 in the cycle that follows the N-th clock edge after the accepting edge.
- R4: With `MOORE = 1`, once `done` is 1, `sum` and `carry_out` take the same values as in R2.
- R5: With `MOORE = 1`, `done` is 1 in the cycle that follows the (N+1)-th clock edge after the accepting edge.
- R6: `in_ready` goes to 0 after an accepting edge and returns to 1 in the cycle where `done` is 1. A request raised while `in_ready` is 0 has no effect on the result.
- R7: While the block is idle and no request is accepted, `sum` and `carry_out` do not change.
- R8: `done` is high for exactly one cycle per accepted request.
- R9: Accepting a request clears the carry state, so a carry left over from the previous addition does not reach the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block is idle and can take a pair |
| in_a | input | N | First operand |
| in_b | input | N | Second operand |
| done | output | 1 | One-cycle pulse when the result is complete |
| sum | output | N | Result word, (in_a + in_b) mod 2^N |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The assertions assume that `in_valid` is a known value on every clock edge after reset. They also assume that the cycle count from acceptance to `done` is not interrupted by another acceptance. This holds because `in_ready` gates acceptance. The stimulus changes inputs only on falling edges. It holds `in_valid` for one cycle per request and sends the next request only after `done` has been seen. It deliberately raises `in_valid` with different operands during a busy period to check that such a request is ignored.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  // Two-state carry core
  typedef enum logic {
    CRY_LO = 1'b0,
    CRY_HI = 1'b1
  } cry_state_t;

  // Four-state core: {carry, sum}
  typedef enum logic [1:0] {
    CS_00 = 2'b00,
    CS_01 = 2'b01,
    CS_10 = 2'b10,
    CS_11 = 2'b11
  } cs_state_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic par3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  // Right shift: the serial bit enters at the top, the lsb leaves at the bottom
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      q <= {ser_in, q[W-1:1]};
    end
  end
endmodule

// File: rtl/sadd_core.sv
module sadd_core
  import sadd_pkg::*;
#(
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic a,
  input  logic b,
  output logic sum_bit,
  output logic carry
);
  generate
    if (MOORE) begin : g_moore
      cs_state_t st_q, st_d;
      logic y_c, y_s;
      assign y_c = st_q[1];
      assign y_s = st_q[0];

      always_comb begin
        st_d = cs_state_t'({maj3(a, b, y_c), par3(a, b, y_c)});
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st_q <= CS_00;
        else if (clear)  st_q <= CS_00;
        else if (step)   st_q <= st_d;
      end

      assign sum_bit = y_s;
      assign carry   = y_c;
    end else begin : g_mealy
      cry_state_t st_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st_q <= CRY_LO;
        else if (clear)  st_q <= CRY_LO;
        else if (step)   st_q <= cry_state_t'(maj3(a, b, st_q));
      end

      assign sum_bit = par3(a, b, st_q);
      assign carry   = st_q;
    end
  endgenerate
endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl #(
  parameter int N     = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic core_step,
  output logic sum_shift,
  output logic done
);
  localparam int STEPS = MOORE ? N + 1 : N;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST_C  = CW'(STEPS - 1);
  localparam logic [CW-1:0] NBITS_C = CW'(N);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign in_ready  = ~busy_q;
  assign load      = in_valid & ~busy_q;
  // The extra flush step of the registered core must not disturb the carry
  assign core_step = busy_q & (cnt_q < NBITS_C);
  assign sum_shift = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST_C) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int N     = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         done,
  output logic [N-1:0] sum,
  output logic         carry_out
);
  logic         load, core_step, sum_shift, sbit;
  logic [N-1:0] opa_q, opb_q;

  sadd_ctrl #(.N(N), .MOORE(MOORE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .core_step(core_step), .sum_shift(sum_shift), .done(done)
  );

  sadd_shreg #(.W(N)) u_opa (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(in_a),
    .shift(core_step), .ser_in(1'b0), .q(opa_q)
  );

  sadd_shreg #(.W(N)) u_opb (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(in_b),
    .shift(core_step), .ser_in(1'b0), .q(opb_q)
  );

  sadd_core #(.MOORE(MOORE)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(core_step),
    .a(opa_q[0]), .b(opb_q[0]), .sum_bit(sbit), .carry(carry_out)
  );

  sadd_shreg #(.W(N)) u_sum (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val({N{1'b0}}),
    .shift(sum_shift), .ser_in(sbit), .q(sum)
  );
endmodule

// File: rtl/sadd_chk.sv
module sadd_chk #(
  parameter int N     = 8,
  parameter bit MOORE = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [N-1:0] sum,
  input logic         carry_out
);
  localparam int LAT = MOORE ? N + 1 : N;
  logic [15:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_q <= '0;
    else if (in_valid && in_ready) lat_q <= '0;
    else if (!in_ready)            lat_q <= lat_q + 16'd1;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(sum) && $stable(carry_out)));

  // R3 R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == 16'(LAT)));
endmodule

bind serial_adder sadd_chk #(.N(N), .MOORE(MOORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .sum(sum), .carry_out(carry_out)
);

// File: tb/sim_serial_adder.sv
`timescale 1ns/1ps
module sim_serial_adder;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld0 = 1'b0, vld1 = 1'b0;
  logic [N-1:0] ina = '0, inb = '0;
  logic rdy0, rdy1, dn0, dn1, co0, co1;
  logic [N-1:0] s0, s1;

  int checks = 0, fails = 0, cyc = 0;
  logic sel = 1'b0;

  always #2.5 clk = ~clk;

  serial_adder #(.N(N), .MOORE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld0), .in_ready(rdy0),
    .in_a(ina), .in_b(inb), .done(dn0), .sum(s0), .carry_out(co0)
  );
  serial_adder #(.N(N), .MOORE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld1), .in_ready(rdy1),
    .in_a(ina), .in_b(inb), .done(dn1), .sum(s1), .carry_out(co1)
  );

  wire         rdy_s = sel ? rdy1 : rdy0;
  wire         dn_s  = sel ? dn1 : dn0;
  wire [N-1:0] sum_s = sel ? s1 : s0;
  wire         co_s  = sel ? co1 : co0;

  function automatic logic [N:0] ref_add(input logic [N-1:0] a, input logic [N-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_add(input logic moore, input logic [N-1:0] a, input logic [N-1:0] b,
                        input logic poke);
    logic [N:0] e;
    int edges;
    e = ref_add(a, b);
    sel = moore;
    @(negedge clk);
    chk("R6 ready before request", 32'(rdy_s), 32'd1);
    ina = a; inb = b;
    if (moore) vld1 = 1'b1; else vld0 = 1'b1;
    @(negedge clk);
    vld0 = 1'b0; vld1 = 1'b0;
    edges = 0;
    chk("R6 ready low while busy", 32'(rdy_s), 32'd0);
    while (!dn_s && edges < 40) begin
      if (poke && edges == 1) begin
        ina = ~a; inb = a;
        if (moore) vld1 = 1'b1; else vld0 = 1'b1;
      end
      @(negedge clk);
      vld0 = 1'b0; vld1 = 1'b0;
      edges++;
    end
    if (moore) chk("R5 latency", 32'(edges), 32'(N + 1));
    else       chk("R3 latency", 32'(edges), 32'(N));
    chk(moore ? "R4 sum" : "R2 sum", 32'(sum_s), 32'(e[N-1:0]));
    chk(moore ? "R4 carry" : "R2 carry", 32'(co_s), 32'(e[N]));
    chk("R6 ready at done", 32'(rdy_s), 32'd1);
    @(negedge clk);
    chk("R8 done one cycle", 32'(dn_s), 32'd0);
    @(negedge clk);
    chk("R7 sum held idle", 32'(sum_s), 32'(e[N-1:0]));
    chk("R7 carry held idle", 32'(co_s), 32'(e[N]));
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned rnd;
    rnd = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ready u0", 32'(rdy0), 32'd1);
    chk("R1 ready u1", 32'(rdy1), 32'd1);
    chk("R1 done", 32'({dn0, dn1}), 32'd0);
    chk("R1 sum", 32'({s0, s1}), 32'd0);
    chk("R1 carry", 32'({co0, co1}), 32'd0);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      // directed corners
      do_add(m[0], 8'h00, 8'h00, 1'b0);
      do_add(m[0], 8'hFF, 8'h01, 1'b0);
      do_add(m[0], 8'hFF, 8'hFF, 1'b0);
      // R9: carry from the previous sum must not leak in
      do_add(m[0], 8'h00, 8'h00, 1'b0);
      do_add(m[0], 8'hAA, 8'h55, 1'b0);
      do_add(m[0], 8'h80, 8'h80, 1'b0);
      // R6: ignored request while busy
      do_add(m[0], 8'h3C, 8'h4D, 1'b1);
      for (int i = 0; i < 40; i++) begin
        do_add(m[0], N'($urandom), N'($urandom), (i % 7) == 3);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule